// File: doc/BRIEF.md
# Banked Memory Chip-Select Decoder

This block sits between a CPU address bus and a set of memory devices. A 3-bit bank number, held in a register written through a port strobe, selects one of eight banks. The decoder combines this number with the top bits of the 16-bit address and a memory-request strobe. From them it drives the select lines for two plain ROMs and one paged ROM, the enable for a pair of 8 KB RAMs, and the selects for two external memory slots.

The selects are not all of one polarity. The ROM and slot selects are active low. The RAM enable is active high. The two RAM chips get complementary enables derived from address bit 13. The paged ROM takes its output enable from address bit 15 and its upper address line from a sub-bank register bit. A high level on an inhibit input turns off the two plain ROM selects, which lets an external device take over their space. Bank and sub-bank writes take effect on the clock edge, so they first change the selects in the following cycle. The selects themselves are combinational in the address, strobe and inhibit inputs.

Top module: `cs_bank_decoder`

## Requirements
- R1: `bank_q` is 0 after reset. When `bank_we` is high at a rising edge, it loads `bank_wdata`, and the selects follow the new bank from the next cycle on.
- R2: `rom_lo_n` is 0 exactly when `mem_req`=1, `addr` is in 0000h–7FFFh, the bank is 0 and `rom_inhibit`=0. Otherwise it is 1.
- R3: `rom_hi_n` is 0 exactly when `mem_req`=1, `addr` is in 8000h–BFFFh, the bank is 6 and `rom_inhibit`=0. Otherwise it is 1.
- R4: `rom_bank_n` is 0 exactly when `mem_req`=1, `addr` is in 4000h–7FFFh and the bank is 3. `rom_bank_oe_n` always equals `addr[15]`.
- R5: `ram_en` is 1 (active high) exactly when `mem_req`=1, `addr` is in C000h–FFFFh and the bank is 0. Otherwise it is 0.
- R6: `ram_lo_ce_n` equals `addr[13]`, which enables the C000h–DFFFh chip. `ram_hi_ce_n` equals the inverse of `addr[13]`, which enables the E000h–FFFFh chip.
- R7: `slot1_n` is 0 exactly when `mem_req`=1, `addr` is in 8000h–BFFFh and the bank is 0 or 1.
- R8: `slot2_n` is 0 exactly when `mem_req`=1, `addr` is in 8000h–BFFFh and the bank is 2 or 3.
- R9: While `rom_inhibit`=1, `rom_lo_n` and `rom_hi_n` are both 1, whatever the address and bank. `rom_bank_n` is not affected.
- R10: While `mem_req`=0, every select is inactive: `rom_lo_n`, `rom_hi_n`, `rom_bank_n`, `slot1_n` and `slot2_n` are 1, and `ram_en` is 0.
- R11: For any address and bank, at most one internal device (low ROM, high ROM, paged ROM, RAM) is selected. Any address/bank pair not named in R2–R8 leaves every select inactive.
- R12: `rom_bank_page` is 0 after reset. When `page_we` is high at a rising edge, it loads `page_wdata` and drives that value from the next cycle on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| addr | input | 16 | CPU address |
| mem_req | input | 1 | Memory request strobe, active high |
| bank_we | input | 1 | Bank register write strobe |
| bank_wdata | input | 3 | New bank number |
| page_we | input | 1 | Sub-bank register write strobe |
| page_wdata | input | 1 | New sub-bank bit |
| rom_inhibit | input | 1 | Forces the plain ROM selects off when high; tie low if unused |
| rom_lo_n | output | 1 | Low ROM select, active low |
| rom_hi_n | output | 1 | High ROM select, active low |
| rom_bank_n | output | 1 | Paged ROM select, active low |
| rom_bank_oe_n | output | 1 | Paged ROM output enable, active low |
| rom_bank_page | output | 1 | Paged ROM upper address line |
| ram_en | output | 1 | Internal RAM pair enable, active high |
| ram_lo_ce_n | output | 1 | Lower 8 KB RAM chip enable, active low |
| ram_hi_ce_n | output | 1 | Upper 8 KB RAM chip enable, active low |
| slot1_n | output | 1 | Slot 1 select, active low |
| slot2_n | output | 1 | Slot 2 select, active low |

## Verification
The assertions sample the combinational selects at the rising edge. They therefore assume that `addr`, `mem_req` and `rom_inhibit` are settled at that edge and that the register write strobes are synchronous. The bench drives every input on the falling edge and compares one nanosecond later, so all inputs are stable around each rising edge. The inhibit input is always driven to a known level, because its board-level pull-down is outside the block. The stimulus covers every bank against window-edge addresses, with the strobe, inhibit and sub-bank bit each taken both ways. It also includes bank writes made during a live request, to show that the old bank holds until the edge.

// File: rtl/cs_pkg.sv
// Package: shared constants and types for the banked chip-select decoder.
// Assumes the address space is split into four equal windows by its top two bits.
package cs_pkg;

    parameter int ADDR_W = 16;
    parameter int BANK_W = 3;

    // Bank numbers that own each device window
    parameter int BANK_ROM_LO    = 0;
    parameter int BANK_ROM_HI    = 6;
    parameter int BANK_ROM_PAGED = 3;
    parameter int BANK_RAM       = 0;

    // Slot banking: each slot owns a run of consecutive banks
    parameter int NUM_SLOTS      = 2;
    parameter int BANKS_PER_SLOT = 2;

    // Quarter-of-space window codes taken from the top two address bits
    typedef enum logic [1:0] {
        WIN_Q0 = 2'b00,   // 0000h-3FFFh
        WIN_Q1 = 2'b01,   // 4000h-7FFFh
        WIN_Q2 = 2'b10,   // 8000h-BFFFh
        WIN_Q3 = 2'b11    // C000h-FFFFh
    } quarter_e;

    // Window flags produced by the address decoder
    typedef struct packed {
        logic lower_half;  // 0000h-7FFFh
        logic q1;          // 4000h-7FFFh
        logic q2;          // 8000h-BFFFh
        logic q3;          // C000h-FFFFh
    } win_t;

endpackage

// File: rtl/cs_bank_regs.sv
// Module: cs_bank_regs
// Holds the bank number and the paged-ROM sub-bank bit. Both are written
// by single-cycle strobes and cleared by synchronous active-low reset.
// Assumes the strobes are synchronous to clk.
module cs_bank_regs #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bank_we,
    input  logic [BANK_W-1:0] bank_wdata,
    input  logic              page_we,
    input  logic              page_wdata,
    output logic [BANK_W-1:0] bank_q,
    output logic              page_q
);

    // Bank number register: load on strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            bank_q <= '0;
        else if (bank_we)
            bank_q <= bank_wdata;
    end

    // Sub-bank bit register: load on strobe, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n)
            page_q <= 1'b0;
        else if (page_we)
            page_q <= page_wdata;
    end

    // R1: a written bank number is visible on the following cycle
    a_r1_bank_load: assert property (@(posedge clk) disable iff (!rst_n)
        bank_we |=> (bank_q == $past(bank_wdata)));

    // R1: without a write the bank number holds
    a_r1_bank_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!bank_we && $past(rst_n)) |=> $stable(bank_q));

    // R12: a written sub-bank bit is visible on the following cycle
    a_r12_page_load: assert property (@(posedge clk) disable iff (!rst_n)
        page_we |=> (page_q == $past(page_wdata)));

endmodule

// File: rtl/cs_window_decode.sv
// Module: cs_window_decode
// Turns the top address bits into window flags and passes the bits that
// drive device pins directly (RAM split bit, paged ROM output enable).
// Assumes ADDR_W >= 14 so that the RAM split bit exists.
module cs_window_decode
    import cs_pkg::*;
#(
    parameter int ADDR_W = 16
) (
    input  logic [ADDR_W-1:0] addr,
    output win_t              win,
    output logic              split_bit,
    output logic              msb
);

    localparam int SPLIT_POS = ADDR_W - 3;

    quarter_e quarter;
    logic     unused_addr_low;

    // Top two bits name the quarter of the address space
    always_comb quarter = quarter_e'(addr[ADDR_W-1 -: 2]);

    // Window flags from the quarter code
    always_comb begin
        win.lower_half = (quarter == WIN_Q0) || (quarter == WIN_Q1);
        win.q1         = (quarter == WIN_Q1);
        win.q2         = (quarter == WIN_Q2);
        win.q3         = (quarter == WIN_Q3);
    end

    // Pin-level pass-through bits
    always_comb begin
        split_bit = addr[SPLIT_POS];
        msb       = addr[ADDR_W-1];
    end

    // Low address bits play no part in decoding
    assign unused_addr_low = ^addr[SPLIT_POS-1:0];

endmodule

// File: rtl/cs_select_gen.sv
// Module: cs_select_gen
// Combines window flags, bank number, request strobe and inhibit into the
// device selects. ROM and slot selects are produced active low, RAM enable
// active high. Slot selects are generated one per slot, each owning
// BANKS_PER_SLOT consecutive banks starting from bank 0.
module cs_select_gen
    import cs_pkg::*;
#(
    parameter int BANK_W    = 3,
    parameter int N_SLOTS   = 2,
    parameter int SLOT_SPAN = 2
) (
    input  win_t               win,
    input  logic [BANK_W-1:0]  bank,
    input  logic               mem_req,
    input  logic               rom_inhibit,
    output logic               rom_lo_n,
    output logic               rom_hi_n,
    output logic               rom_bank_n,
    output logic               ram_en,
    output logic [N_SLOTS-1:0] slot_n
);

    localparam logic [BANK_W-1:0] B_LO    = BANK_W'(BANK_ROM_LO);
    localparam logic [BANK_W-1:0] B_HI    = BANK_W'(BANK_ROM_HI);
    localparam logic [BANK_W-1:0] B_PAGED = BANK_W'(BANK_ROM_PAGED);
    localparam logic [BANK_W-1:0] B_RAM   = BANK_W'(BANK_RAM);

    logic rom_gate;

    // Plain ROMs need a request and no external inhibit
    always_comb rom_gate = mem_req && !rom_inhibit;

    // Internal ROM selects, active low
    always_comb begin
        rom_lo_n   = !(rom_gate && win.lower_half && (bank == B_LO));
        rom_hi_n   = !(rom_gate && win.q2         && (bank == B_HI));
        rom_bank_n = !(mem_req  && win.q1         && (bank == B_PAGED));
    end

    // Internal RAM enable, active high
    always_comb ram_en = mem_req && win.q3 && (bank == B_RAM);

    // One select per slot over its own run of banks
    for (genvar s = 0; s < N_SLOTS; s++) begin : g_slot
        localparam logic [BANK_W:0] FIRST = (BANK_W+1)'(s * SLOT_SPAN);
        localparam logic [BANK_W:0] LAST  = (BANK_W+1)'((s + 1) * SLOT_SPAN);
        logic in_run;
        // Bank falls inside this slot's run
        always_comb in_run = ({1'b0, bank} >= FIRST) && ({1'b0, bank} < LAST);
        // Slot select, active low
        always_comb slot_n[s] = !(mem_req && win.q2 && in_run);
    end

endmodule

// File: rtl/cs_bank_decoder.sv
// Module: cs_bank_decoder (top)
// Banked chip-select decoder: bank/sub-bank registers, address window
// decode and select generation. Selects are combinational in addr,
// mem_req and rom_inhibit and registered only through the bank state.
// Assumes inputs are stable around each rising clock edge.
module cs_bank_decoder
    import cs_pkg::*;
#(
    parameter int AW = ADDR_W,
    parameter int BW = BANK_W
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [AW-1:0] addr,
    input  logic          mem_req,
    input  logic          bank_we,
    input  logic [BW-1:0] bank_wdata,
    input  logic          page_we,
    input  logic          page_wdata,
    input  logic          rom_inhibit,
    output logic          rom_lo_n,
    output logic          rom_hi_n,
    output logic          rom_bank_n,
    output logic          rom_bank_oe_n,
    output logic          rom_bank_page,
    output logic          ram_en,
    output logic          ram_lo_ce_n,
    output logic          ram_hi_ce_n,
    output logic          slot1_n,
    output logic          slot2_n
);

    logic [BW-1:0]        bank_q;
    logic                 page_q;
    win_t                 win;
    logic                 split_bit;
    logic                 msb;
    logic [NUM_SLOTS-1:0] slot_n;

    cs_bank_regs #(.BANK_W(BW)) regs_i (
        .clk        (clk),
        .rst_n      (rst_n),
        .bank_we    (bank_we),
        .bank_wdata (bank_wdata),
        .page_we    (page_we),
        .page_wdata (page_wdata),
        .bank_q     (bank_q),
        .page_q     (page_q)
    );

    cs_window_decode #(.ADDR_W(AW)) win_i (
        .addr      (addr),
        .win       (win),
        .split_bit (split_bit),
        .msb       (msb)
    );

    cs_select_gen #(
        .BANK_W    (BW),
        .N_SLOTS   (NUM_SLOTS),
        .SLOT_SPAN (BANKS_PER_SLOT)
    ) sel_i (
        .win         (win),
        .bank        (bank_q),
        .mem_req     (mem_req),
        .rom_inhibit (rom_inhibit),
        .rom_lo_n    (rom_lo_n),
        .rom_hi_n    (rom_hi_n),
        .rom_bank_n  (rom_bank_n),
        .ram_en      (ram_en),
        .slot_n      (slot_n)
    );

    // Device pin wiring: RAM split, paged ROM enable and page line
    always_comb begin
        ram_lo_ce_n   = split_bit;
        ram_hi_ce_n   = !split_bit;
        rom_bank_oe_n = msb;
        rom_bank_page = page_q;
        slot1_n       = slot_n[0];
        slot2_n       = slot_n[1];
    end

    // R10: no request, no select
    a_r10_idle: assert property (@(posedge clk) disable iff (!rst_n)
        !mem_req |-> (rom_lo_n && rom_hi_n && rom_bank_n && !ram_en && slot1_n && slot2_n));

    // R9: inhibit keeps both plain ROMs deselected
    a_r9_inhibit: assert property (@(posedge clk) disable iff (!rst_n)
        rom_inhibit |-> (rom_lo_n && rom_hi_n));

    // R11: internal devices never contend
    a_r11_one_device: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({!rom_lo_n, !rom_hi_n, !rom_bank_n, ram_en}));

    // R5: RAM enable only in the top quarter
    a_r5_ram_window: assert property (@(posedge clk) disable iff (!rst_n)
        ram_en |-> (addr[AW-1 -: 2] == 2'b11));

    // R7, R8: slots only in the third quarter and never together
    a_r7_slot_window: assert property (@(posedge clk) disable iff (!rst_n)
        (!slot1_n || !slot2_n) |-> (addr[AW-1 -: 2] == 2'b10 && (slot1_n != slot2_n)));

    // R6: exactly one RAM chip enable is low
    a_r6_split: assert property (@(posedge clk) disable iff (!rst_n)
        $countones({ram_lo_ce_n, ram_hi_ce_n}) == 1);

endmodule

// File: tb/cs_bank_decoder_tb_top.sv
`timescale 1ns/1ps
module cs_bank_decoder_tb_top;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [15:0] addr = '0;
    logic        mem_req = 1'b0;
    logic        bank_we = 1'b0;
    logic [2:0]  bank_wdata = '0;
    logic        page_we = 1'b0;
    logic        page_wdata = 1'b0;
    logic        rom_inhibit = 1'b0;
    logic rom_lo_n, rom_hi_n, rom_bank_n, rom_bank_oe_n, rom_bank_page;
    logic ram_en, ram_lo_ce_n, ram_hi_ce_n, slot1_n, slot2_n;

    int checks = 0;
    int fails  = 0;
    int m_bank = 0;
    int m_page = 0;

    always #2 clk = ~clk;

    cs_bank_decoder dut_i (
        .clk(clk), .rst_n(rst_n), .addr(addr), .mem_req(mem_req),
        .bank_we(bank_we), .bank_wdata(bank_wdata),
        .page_we(page_we), .page_wdata(page_wdata),
        .rom_inhibit(rom_inhibit),
        .rom_lo_n(rom_lo_n), .rom_hi_n(rom_hi_n), .rom_bank_n(rom_bank_n),
        .rom_bank_oe_n(rom_bank_oe_n), .rom_bank_page(rom_bank_page),
        .ram_en(ram_en), .ram_lo_ce_n(ram_lo_ce_n), .ram_hi_ce_n(ram_hi_ce_n),
        .slot1_n(slot1_n), .slot2_n(slot2_n)
    );

    task automatic chk(input string tag, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s addr=%h bank=%0d req=%0b inh=%0b: got %b expected %b",
                     tag, addr, m_bank, mem_req, rom_inhibit, act, exp);
        end
    endtask

    // Compare every output against the behavioural model
    task automatic compare_all();
        int  a = int'(addr);
        bit  q = mem_req;
        bit  inh = rom_inhibit;
        bit  in_lo  = (a < 'h8000);
        bit  in_pg  = (a >= 'h4000 && a < 'h8000);
        bit  in_mid = (a >= 'h8000 && a < 'hC000);
        bit  in_top = (a >= 'hC000);
        bit  e_lo  = q && in_lo  && m_bank == 0 && !inh;
        bit  e_hi  = q && in_mid && m_bank == 6 && !inh;
        bit  e_pg  = q && in_pg  && m_bank == 3;
        bit  e_ram = q && in_top && m_bank == 0;
        bit  e_s1  = q && in_mid && (m_bank == 0 || m_bank == 1);
        bit  e_s2  = q && in_mid && (m_bank == 2 || m_bank == 3);
        chk(inh ? "R9 rom_lo_n" : "R2 rom_lo_n", rom_lo_n, !e_lo);
        chk(inh ? "R9 rom_hi_n" : "R3 rom_hi_n", rom_hi_n, !e_hi);
        chk("R4 rom_bank_n", rom_bank_n, !e_pg);
        chk("R4 rom_bank_oe_n", rom_bank_oe_n, a >= 'h8000);
        chk("R12 rom_bank_page", rom_bank_page, m_page[0]);
        chk("R5 ram_en", ram_en, e_ram);
        chk("R6 ram_lo_ce_n", ram_lo_ce_n, ((a / 'h2000) % 2) == 1);
        chk("R6 ram_hi_ce_n", ram_hi_ce_n, ((a / 'h2000) % 2) == 0);
        chk("R7 slot1_n", slot1_n, !e_s1);
        chk("R8 slot2_n", slot2_n, !e_s2);
        if (!q)
            chk("R10 idle", rom_lo_n & rom_hi_n & rom_bank_n & !ram_en & slot1_n & slot2_n, 1'b1);
        chk("R11 one device",
            ((!rom_lo_n) + (!rom_hi_n) + (!rom_bank_n) + ram_en) <= 1, 1'b1);
    endtask

    // One cycle: drive at falling edge, compare, then let the edge commit writes
    task automatic step(input logic [15:0] a, input bit q, input bit inh,
                        input bit bwe, input int bdat, input bit pwe, input bit pdat);
        @(negedge clk);
        addr = a; mem_req = q; rom_inhibit = inh;
        bank_we = bwe; bank_wdata = 3'(bdat);
        page_we = pwe; page_wdata = pdat;
        #1;
        compare_all();
        @(posedge clk);
        if (bwe) m_bank = bdat;
        if (pwe) m_page = int'(pdat);
    endtask

    initial begin
        #800000;
        fails++;
        checks++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

    initial begin
        logic [15:0] edges [12] = '{16'h0000, 16'h1FFF, 16'h3FFF, 16'h4000, 16'h7FFF,
                                    16'h8000, 16'hA123, 16'hBFFF, 16'hC000, 16'hDFFF,
                                    16'hE000, 16'hFFFF};
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1, R12: reset state seen through the selects
        step(16'h0100, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        chk("R1 reset bank 0 selects low ROM", rom_lo_n, 1'b0);
        chk("R12 reset page 0", rom_bank_page, 1'b0);
        for (int b = 0; b < 8; b++) begin
            // R1: write during a live request; old bank holds this cycle
            step(16'hC010, 1'b1, 1'b0, 1'b1, b, 1'b1, b[0]);
            for (int e = 0; e < 12; e++)
                for (int k = 0; k < 4; k++)
                    step(edges[e], k[0], k[1], 1'b0, 0, 1'b0, 1'b0);
        end
        // R12: sub-bank toggling inside the paged window
        step(16'h5555, 1'b1, 1'b0, 1'b1, 3, 1'b1, 1'b1);
        step(16'h5555, 1'b1, 1'b0, 1'b0, 0, 1'b1, 1'b0);
        step(16'h5555, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        // R9: inhibit leaves the paged ROM selected
        step(16'h6000, 1'b1, 1'b1, 1'b0, 0, 1'b0, 1'b0);
        chk("R9 paged ROM unaffected by inhibit", rom_bank_n, 1'b0);
        // R1: back-to-back bank writes
        step(16'h9000, 1'b1, 1'b0, 1'b1, 6, 1'b0, 1'b0);
        step(16'h9000, 1'b1, 1'b0, 1'b1, 2, 1'b0, 1'b0);
        step(16'h9000, 1'b1, 1'b0, 1'b0, 0, 1'b0, 1'b0);
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end

endmodule